// File: doc/BRIEF.md
# Segmented and Paged Address Translator

This block turns a logical address, a 16-bit segment selector plus a 32-bit offset, into a physical address. The translation runs in two chained stages.

The first stage reads the selector from one of six segment registers. A selector bit picks either the local or the global descriptor table. The block then fetches the 8-byte descriptor in two 32-bit reads. After checking the offset against the segment limit, it adds the offset to the segment base to form a 32-bit linear address. The second stage walks a page directory, whose root comes from a directory-base input, and then a page table. A size flag in the directory entry can end the walk early for a 4 MB page.

All table reads go through a single memory read port, with at most one read in flight. A translation ends in a one-cycle completion pulse that carries either the physical address or a fault code.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `done` and `mem_rd` are 0, and all six segment registers hold selector 0.
- R2: A selector is split into a descriptor index in bits [15:3], a table select in bit 2 (1 = local table at `ltab_base`, 0 = global table at `gtab_base`) and a privilege field in bits [1:0]. The privilege field is stored with the selector but has no effect on translation. The descriptor address is the table base plus the index times 8.
- R3: The descriptor is read as two words. The word at the descriptor address is the segment base, and the word at the descriptor address plus 4 is the inclusive byte limit. Only one read is outstanding at a time, and each `mem_rd` is a one-cycle pulse.
- R4: An offset greater than the limit ends the translation with `fault_code` 1, `lin_addr` 0 and `phys_addr` 0, after exactly two reads. An offset equal to the limit is legal.
- R5: The linear address is the segment base plus the offset, modulo 2^32. It is reported on `lin_addr` for every translation that passes the limit check.
- R6: The directory entry is read at `dir_base` plus `lin_addr[31:22]` times 4. If its bit 0 (present) is 0, the translation ends with `fault_code` 2 and `phys_addr` 0, after three reads.
- R7: A present directory entry with bit 7 (page-size flag) set maps a 4 MB page. The result is `phys_addr` = {entry[31:22], lin[21:0]} with fault code 0, after three reads.
- R8: Otherwise the table entry is read at {entry[31:12], 12'b0} plus `lin[21:12]` times 4. If its bit 0 is 0, the result is `fault_code` 3 with `phys_addr` 0. If bit 0 is 1, the result is `phys_addr` = {pte[31:12], lin[11:0]}. Either way the walk takes four reads.
- R9: A `seg_wr` pulse loads `seg_wr_sel` into the segment register numbered `seg_wr_idx` (0 to 5). Later requests naming that register use the new selector.
- R10: A request is accepted only when `req_valid` and `req_ready` are both 1. Requests made while a walk is in progress are ignored. Each accepted request produces exactly one one-cycle `done` pulse.
- R11: `dir_base` may change between translations, as on a context switch. The next walk uses the new directory root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr | input | 1 | Load strobe for a segment register |
| seg_wr_idx | input | 3 | Segment register to load |
| seg_wr_sel | input | 16 | Selector value to load |
| ltab_base | input | 32 | Base address of the local descriptor table |
| gtab_base | input | 32 | Base address of the global descriptor table |
| dir_base | input | 32 | Root address of the current page directory |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Segment register used by the request |
| req_off | input | 32 | Offset within the segment |
| req_ready | output | 1 | Block is idle and can accept a request |
| mem_rd | output | 1 | One-cycle table read strobe |
| mem_addr | output | 32 | Byte address of the table read |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 limit, 2 directory entry absent, 3 table entry absent |
| lin_addr | output | 32 | Linear address of the finished translation |
| phys_addr | output | 32 | Physical address, 0 on a fault |

## Verification
The bench places the offset exactly at the limit and one byte past it. A design with an off-by-one compare would either reject the legal byte or walk the pages for an illegal one, and the read count shows the second case. The bench runs one segment whose base plus offset wraps past 2^32, uses both tables with a nonzero privilege field, and maps a 4 MB page. A design that carried out of the adder, swapped the table-select sense, mixed the privilege bits into the index, or ignored the size flag would produce a wrong address or a fourth read. It also reloads a segment register and the directory root between walks, and raises requests while a walk is busy. A design that latched stale state or accepted a second request would return the wrong frame or emit an extra `done`.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the segmented/paged translator.
// Assumes a 32-bit byte address space and 4-byte table words.
package xlate_pkg;
    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int DIX_W    = 13;   // descriptor index width
    localparam int PG_OFF_W = 12;   // 4 KB page offset
    localparam int BIG_OFF_W = 22;  // 4 MB page offset
    localparam int LVL_IX_W = 10;   // index width at each paging level
    localparam int FRM_W    = ADDR_W - PG_OFF_W;
    localparam int BIG_FRM_W = ADDR_W - BIG_OFF_W;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_DIR   = 2'd2,
        FLT_TBL   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BASE, ST_LIMIT, ST_DIR, ST_TBL
    } walk_st_e;
endpackage

// File: rtl/xlate_segregs.sv
// Bank of segment registers holding loaded selectors.
// Assumes writes to an index at or above NUM_SEGS are dropped and
// such indices read as zero. Read port is combinational.
module xlate_segregs #(
    parameter int NUM_SEGS = 6,
    parameter int SEL_W    = 16,
    localparam int IX_W    = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [IX_W-1:0]  rd_idx,
    output logic [SEL_W-1:0] rd_sel
);
    logic [SEL_W-1:0] regs [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_reg
        // Load one selector register on a matching write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IX_W'(g))
                regs[g] <= wr_sel;
        end
    end

    // Select the register named by the request.
    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_SEGS; i++)
            if (rd_idx == IX_W'(i))
                rd_sel = regs[i];
    end
endmodule

// File: rtl/xlate_pgdec.sv
// Paging entry address arithmetic, purely combinational.
// Assumes page tables are 4 KB aligned and entries are 4 bytes.
module xlate_pgdec
    import xlate_pkg::*;
(
    input  logic [FRM_W-1:0]  ent_frame,  // entry bits [31:12]
    input  logic [ADDR_W-1:0] lin,
    output logic [ADDR_W-1:0] tbl_addr,   // next-level entry address
    output logic [ADDR_W-1:0] phys_big,   // 4 MB page result
    output logic [ADDR_W-1:0] phys_small  // 4 KB page result
);
    // Form the table entry address and the two page results.
    always_comb begin
        tbl_addr   = {ent_frame, {PG_OFF_W{1'b0}}}
                   + {{(ADDR_W-LVL_IX_W-2){1'b0}}, lin[BIG_OFF_W-1:PG_OFF_W], 2'b00};
        phys_big   = {ent_frame[FRM_W-1:FRM_W-BIG_FRM_W], lin[BIG_OFF_W-1:0]};
        phys_small = {ent_frame, lin[PG_OFF_W-1:0]};
    end
endmodule

// File: rtl/xlate_walker.sv
// Sequencer for descriptor fetch, limit check and page walk.
// Assumes a memory that answers each read with one mem_rvalid pulse
// some cycles later; only one read is ever outstanding.
module xlate_walker
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:2]  sel,        // privilege bits not needed here
    input  logic [ADDR_W-1:0] off,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              done,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    walk_st_e          state;
    logic [ADDR_W-1:0] off_q, base_q;
    logic [ADDR_W-1:0] lin_next, desc_addr, dir_addr;
    logic [ADDR_W-1:0] tbl_addr, phys_big, phys_small;

    // Descriptor, linear and directory entry addresses.
    always_comb begin
        desc_addr = (sel[2] ? ltab_base : gtab_base)
                  + {{(ADDR_W-DIX_W-3){1'b0}}, sel[SEL_W-1:3], 3'b000};
        lin_next  = base_q + off_q;
        dir_addr  = dir_base
                  + {{(ADDR_W-LVL_IX_W-2){1'b0}}, lin_next[ADDR_W-1:BIG_OFF_W], 2'b00};
    end

    xlate_pgdec u_dec (
        .ent_frame (mem_rdata[ADDR_W-1:PG_OFF_W]),
        .lin       (lin_addr),
        .tbl_addr  (tbl_addr),
        .phys_big  (phys_big),
        .phys_small(phys_small)
    );

    assign busy = (state != ST_IDLE);

    // Walk state machine: issue reads, check limit and present bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mem_rd     <= 1'b0;
            mem_addr   <= '0;
            done       <= 1'b0;
            fault_code <= FLT_NONE;
            lin_addr   <= '0;
            phys_addr  <= '0;
            off_q      <= '0;
            base_q     <= '0;
        end else begin
            mem_rd <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    off_q    <= off;
                    mem_addr <= desc_addr;
                    mem_rd   <= 1'b1;
                    state    <= ST_BASE;
                end
                ST_BASE: if (mem_rvalid) begin
                    base_q   <= mem_rdata;
                    mem_addr <= mem_addr + ADDR_W'(4);
                    mem_rd   <= 1'b1;
                    state    <= ST_LIMIT;
                end
                ST_LIMIT: if (mem_rvalid) begin
                    if (off_q > mem_rdata) begin
                        lin_addr   <= '0;
                        phys_addr  <= '0;
                        fault_code <= FLT_LIMIT;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        lin_addr <= lin_next;
                        mem_addr <= dir_addr;
                        mem_rd   <= 1'b1;
                        state    <= ST_DIR;
                    end
                end
                ST_DIR: if (mem_rvalid) begin
                    if (!mem_rdata[0]) begin
                        phys_addr  <= '0;
                        fault_code <= FLT_DIR;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (mem_rdata[7]) begin
                        phys_addr  <= phys_big;
                        fault_code <= FLT_NONE;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        mem_addr <= tbl_addr;
                        mem_rd   <= 1'b1;
                        state    <= ST_TBL;
                    end
                end
                ST_TBL: if (mem_rvalid) begin
                    phys_addr  <= mem_rdata[0] ? phys_small : '0;
                    fault_code <= mem_rdata[0] ? FLT_NONE : FLT_TBL;
                    done       <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_page_xlate.sv
// Top: segment registers feeding a descriptor-then-page walker.
// Assumes table bases are stable from request to done.
module seg_page_xlate
    import xlate_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    localparam int SIX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr,
    input  logic [SIX_W-1:0]  seg_wr_idx,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [ADDR_W-1:0] ltab_base,
    input  logic [ADDR_W-1:0] gtab_base,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    input  logic [SIX_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_off,
    output logic              req_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] lin_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [SEL_W-1:0] cur_sel;
    logic             busy;

    xlate_segregs #(.NUM_SEGS(NUM_SEGS), .SEL_W(SEL_W)) u_segs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (seg_wr),
        .wr_idx(seg_wr_idx),
        .wr_sel(seg_wr_sel),
        .rd_idx(req_seg),
        .rd_sel(cur_sel)
    );

    xlate_walker u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_valid && !busy),
        .sel       (cur_sel[SEL_W-1:2]),
        .off       (req_off),
        .ltab_base (ltab_base),
        .gtab_base (gtab_base),
        .dir_base  (dir_base),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .done      (done),
        .fault_code(fault_code),
        .lin_addr  (lin_addr),
        .phys_addr (phys_addr)
    );

    assign req_ready = !busy;
endmodule

// File: rtl/seg_page_xlate_chk.sv
// Checker bound to the translator top; observes ports only.
module seg_page_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_rd,
    input logic        done,
    input logic [1:0]  fault_code,
    input logic [31:0] lin_addr,
    input logic [31:0] phys_addr
);
    // R1: the cycle after reset the block is idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !done && !mem_rd));

    // R3: a read is never issued while the block reports idle
    assert_rd_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);

    // R3: each read strobe lasts one cycle
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a limit fault reports neither a linear nor a physical address
    assert_limit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 2'd1) |-> (lin_addr == 32'd0 && phys_addr == 32'd0));

    // R6: any fault yields no physical address
    assert_fault_no_phys_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 2'd0) |-> phys_addr == 32'd0);

    // R8: a good translation keeps the low 12 offset bits
    assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 2'd0) |-> phys_addr[11:0] == lin_addr[11:0]);
endmodule

bind seg_page_xlate seg_page_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_rd    (mem_rd),
    .done      (done),
    .fault_code(fault_code),
    .lin_addr  (lin_addr),
    .phys_addr (phys_addr)
);

// File: tb/seg_page_xlate_test.sv
// Bench: vector table walk, then directed reset and corner tests.
module seg_page_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr = 1'b0;
    logic [2:0]  seg_wr_idx = '0;
    logic [15:0] seg_wr_sel = '0;
    logic [31:0] ltab_base = 32'h100;
    logic [31:0] gtab_base = 32'h200;
    logic [31:0] dir_base  = 32'h400;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [31:0] req_off = '0;
    logic        req_ready, mem_rd, mem_rvalid, done;
    logic [31:0] mem_addr, mem_rdata, lin_addr, phys_addr;
    logic [1:0]  fault_code;

    always #5 clk = ~clk;

    seg_page_xlate uut (.*);

    // Memory model: one-cycle read latency, logs read addresses.
    logic [31:0] mem [2048];
    logic [31:0] rd_hist [256];
    int unsigned rd_cnt = 0;
    int unsigned done_cnt = 0;
    initial mem_rvalid = 1'b0;
    initial mem_rdata  = '0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[12:2]];
            rd_hist[rd_cnt[7:0]] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<50000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load_seg(input logic [2:0] idx, input logic [15:0] sel);
        @(negedge clk);
        seg_wr = 1'b1; seg_wr_idx = idx; seg_wr_sel = sel;
        @(negedge clk);
        seg_wr = 1'b0;
    endtask

    // Issue one translation and collect its result at the done pulse.
    task automatic xlate(input logic [2:0] seg, input logic [31:0] off,
                         output logic [1:0] code, output logic [31:0] lin,
                         output logic [31:0] phys, output int unsigned nrd,
                         output logic [31:0] first);
        int unsigned s;
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        s = rd_cnt;
        req_valid = 1'b1; req_seg = seg; req_off = off;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        code = fault_code; lin = lin_addr; phys = phys_addr;
        nrd = rd_cnt - s;
        first = rd_hist[s[7:0]];
    endtask

    typedef struct packed {
        logic [2:0]  seg;
        logic [31:0] off;
        logic [1:0]  code;
        logic [31:0] lin;
        logic [31:0] phys;
        logic [3:0]  nrd;
        logic [31:0] desc;
    } vec_t;

    // seg0 = local idx1, seg1 = global idx2 prv3, seg2 = global idx3, seg3 = global idx4
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 32'h0000_1234, 2'd0, 32'h0040_1234, 32'h0ABC_D234, 4'd4, 32'h108}, // R8 R2 local
        '{3'd0, 32'h0000_3010, 2'd3, 32'h0040_3010, 32'h0,         4'd4, 32'h108}, // R8 absent pte
        '{3'd0, 32'h0000_FFFF, 2'd0, 32'h0040_FFFF, 32'h0005_5FFF, 4'd4, 32'h108}, // R4 at limit
        '{3'd0, 32'h0001_0000, 2'd1, 32'h0,         32'h0,         4'd2, 32'h108}, // R4 past limit
        '{3'd1, 32'h0012_3456, 2'd0, 32'h00D2_3456, 32'h7FD2_3456, 4'd3, 32'h210}, // R7 R2 global
        '{3'd2, 32'h0000_2345, 2'd2, 32'h0100_2345, 32'h0,         4'd3, 32'h218}, // R6 absent pde
        '{3'd3, 32'h0000_2000, 2'd0, 32'h0000_1000, 32'h0ABC_D000, 4'd4, 32'h220}  // R5 wrap
    };

    logic [1:0]  r_code;
    logic [31:0] r_lin, r_phys, r_first;
    int unsigned r_nrd;

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        // descriptors: {base, limit}
        mem[12'h108 >> 2] = 32'h0040_0000; mem[12'h10C >> 2] = 32'h0000_FFFF;
        mem[12'h200 >> 2] = 32'h0;         mem[12'h204 >> 2] = 32'h0;
        mem[12'h210 >> 2] = 32'h00C0_0000; mem[12'h214 >> 2] = 32'h00FF_FFFF;
        mem[12'h218 >> 2] = 32'h0100_0000; mem[12'h21C >> 2] = 32'hFFFF_FFFF;
        mem[12'h220 >> 2] = 32'hFFFF_F000; mem[12'h224 >> 2] = 32'hFFFF_FFFF;
        // directory at 0x400
        mem[12'h400 >> 2] = 32'h0000_1001;
        mem[12'h404 >> 2] = 32'h0000_1001;
        mem[12'h40C >> 2] = 32'h7FC0_0081;
        // second directory at 0x800
        mem[12'h804 >> 2] = 32'h12C0_0081;
        // page table at 0x1000
        mem[13'h1004 >> 2] = 32'h0ABC_D001;
        mem[13'h103C >> 2] = 32'h0005_5001;

        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'b0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", {31'b0, req_ready}, 32'd1);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 mem_rd", {31'b0, mem_rd}, 32'd0);

        // R1: unloaded register holds selector 0 -> global idx0 -> absent pte
        xlate(3'd5, 32'h0, r_code, r_lin, r_phys, r_nrd, r_first);
        check("R1 reset seg desc addr", r_first, 32'h200);
        check("R1 reset seg code", {30'b0, r_code}, 32'd3);

        load_seg(3'd0, 16'h000C);
        load_seg(3'd1, 16'h0013);
        load_seg(3'd2, 16'h0018);
        load_seg(3'd3, 16'h0020);

        for (int v = 0; v < NV; v++) begin
            xlate(VEC[v].seg, VEC[v].off, r_code, r_lin, r_phys, r_nrd, r_first);
            check($sformatf("R2 R3 vec%0d desc addr", v), r_first, VEC[v].desc);
            check($sformatf("R4 R6 R8 vec%0d code", v), {30'b0, r_code}, {30'b0, VEC[v].code});
            check($sformatf("R5 vec%0d lin", v), r_lin, VEC[v].lin);
            check($sformatf("R7 R8 vec%0d phys", v), r_phys, VEC[v].phys);
            check($sformatf("R3 R7 vec%0d reads", v), r_nrd, {28'b0, VEC[v].nrd});
        end

        // R9: reload seg0 with global idx3 -> uses that descriptor
        load_seg(3'd0, 16'h0018);
        xlate(3'd0, 32'h0000_2345, r_code, r_lin, r_phys, r_nrd, r_first);
        check("R9 reload desc addr", r_first, 32'h218);
        check("R9 reload lin", r_lin, 32'h0100_2345);
        check("R9 reload code", {30'b0, r_code}, 32'd2);
        load_seg(3'd0, 16'h000C);

        // R10: requests during a walk are ignored, one done per accepted request
        begin
            int unsigned d0;
            @(negedge clk);
            d0 = done_cnt;
            req_valid = 1'b1; req_seg = 3'd0; req_off = 32'h0000_1234;
            @(negedge clk);
            req_seg = 3'd1; req_off = 32'h0012_3456;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            repeat (30) @(negedge clk);
            check("R10 single done", done_cnt - d0, 32'd1);
            check("R10 first result kept", phys_addr, 32'h0ABC_D234);
        end

        // R11: new directory root on context switch
        dir_base = 32'h800;
        xlate(3'd0, 32'h0000_1234, r_code, r_lin, r_phys, r_nrd, r_first);
        check("R11 new root phys", r_phys, 32'h12C0_1234);
        check("R11 new root reads", r_nrd, 32'd3);
        check("R11 dir read addr", rd_hist[(rd_cnt - 1) & 255], 32'h804);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule